// File: doc/BRIEF.md
# TDM Audio Slot Serializer

This block places up to several channels of parallel audio samples onto one time-division-multiplexed serial data line. The bus master supplies the bit clock and the frame sync. The block runs on its own faster system clock. It oversamples both framing inputs, picks out the chosen bit-clock edge as its launch point, and treats a rising frame sync seen on a launch edge as the start of a frame. After a programmable number of bit clocks of offset, it walks the slots in ascending order from slot 0. Each bit clock it sends one bit of the channel word mapped to the current slot, most significant bit first.

Each channel has an enable and a 6-bit slot number, so a frame can hold up to 64 slots. The block drives its output enable only while one of its own slots is on the line. Other transmitters can therefore share the wire. All samples are copied into a shadow register when a frame starts, so a host that writes new samples during the frame does not disturb it.

The block counts bit clocks between frame-sync edges and raises a sticky error flag when a frame is too short for the data it is configured to carry. A frame sync that arrives in the middle of a slot is held back until that slot is complete. The sequence then restarts at slot 0.

Top module: `tdm_slot_tx`

## Requirements
- R1: A frame starts on the first launch edge at which the sampled frame sync is 1 after having been 0 on the previous launch edge. The MSB of slot 0 is sent `cfg_offset` bit clocks after that edge; with offset 0 it is sent on that same edge. Before that bit, `sdout_oe` is 0.
- R2: Slots are sent in ascending order from 0 through the highest slot number held by an enabled channel. Each slot lasts one word. A slot carries the enabled channel c whose field `cfg_ch_slot[6c+5:6c]` equals the slot number, and the lowest such c wins a tie. The transmitted word is the low word-length bits of `samples[32c+31:32c]`, highest of those bits first, one bit per launch edge.
- R3: `cfg_launch_fall` = 0 selects the rising bit-clock edge as the launch edge, and 1 selects the falling edge. `sdout` and `sdout_oe` change only in response to a launch edge, within SYNC_STAGES+1 system clocks of it. The bit clock must have a period of well over that many system clocks.
- R4: The word length is `cfg_wlen_m1` + 1, from 1 to 32 bits, and it sets both the slot width and the number of bits sent per word.
- R5: `sdout_oe` is 1 only during bits of slots held by an enabled channel, including slot 63. While it is 0, `sdout` is 0.
- R6: All channel samples are captured at the start of each frame. Changes on `samples` after that point do not change the bits sent in that frame.
- R7: The block counts bit clocks from one frame-sync rising edge to the next. When that count is less than (number of enabled channels) × word length + `cfg_offset`, `frame_err` becomes 1. No check is made at the first edge after reset. Once set, the flag stays 1 until reset.
- R8: A frame-sync rising edge that arrives while a slot is partly sent does not cut that slot short. At the first launch edge after the slot's last bit, a new frame starts at slot 0 with freshly captured samples, and the offset is counted from that edge.
- R9: While reset is active and just after it is released, `sdout`, `sdout_oe` and `frame_err` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bclk | input | 1 | Bit clock from the bus master |
| fsync | input | 1 | Frame sync from the bus master |
| cfg_launch_fall | input | 1 | Launch edge select: 0 rising, 1 falling |
| cfg_wlen_m1 | input | 5 | Word length minus one |
| cfg_offset | input | 8 | Bit clocks from frame start to the slot 0 MSB |
| cfg_ch_en | input | 4 | Per-channel enable |
| cfg_ch_slot | input | 24 | Per-channel slot number, 6 bits per channel |
| samples | input | 128 | Per-channel sample words, 32 bits per channel |
| sdout | output | 1 | Serial data, 0 when not driven |
| sdout_oe | output | 1 | High while this block owns the current bit |
| frame_err | output | 1 | Sticky flag: a frame was too short |

## Verification
A sequencer that holds a wrong slot or bit counter shows up on the very next launch edge. The bench sees it as a wrong bit or a misplaced output enable, and every slot boundary is compared bit by bit. A wrong idea of the frame start or of the offset shifts the whole word by one or more bit clocks, so the first miscompare appears at the slot 0 MSB. A shadow register that is not isolated from the inputs, or a resync that fires at the wrong point, corrupts the bits sent right after the sample change or the early frame sync. The frame-length counter is visible only through `frame_err` once the next frame-sync edge has been seen, so the bench reads that flag after each closing edge.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
   localparam int SLOT_W   = 6;
   localparam int SLOT_MAX = 1 << SLOT_W;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_OFFS = 2'd1,
      ST_SEND = 2'd2
   } tx_st_e;

   function automatic int ch_bits(int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/tdm_edge.sv
module tdm_edge #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bclk,
   input  logic fsync,
   input  logic launch_fall,
   output logic tick,
   output logic fs_edge
);
   logic [1:0] raw;
   logic [1:0] syn;
   logic       bclk_q;
   logic       fs_last;

   assign raw = {fsync, bclk};

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign syn = raw;
      end else begin : g_sync
         logic [1:0] chain [SYNC_STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < SYNC_STAGES; i++) chain[i] <= '0;
            end else begin
               chain[0] <= raw;
               for (int i = 1; i < SYNC_STAGES; i++) chain[i] <= chain[i-1];
            end
         end
         assign syn = chain[SYNC_STAGES-1];
      end
   endgenerate

   assign tick    = launch_fall ? (bclk_q & ~syn[0]) : (syn[0] & ~bclk_q);
   assign fs_edge = tick & syn[1] & ~fs_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bclk_q  <= 1'b0;
         fs_last <= 1'b0;
      end else begin
         bclk_q <= syn[0];
         if (tick) fs_last <= syn[1];
      end
   end

   AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick); // R3
endmodule

// File: rtl/tdm_slotmap.sv
module tdm_slotmap
   import tdm_pkg::*;
#(
   parameter int NCH = 4
) (
   input  logic [NCH-1:0]            ch_en,
   input  logic [NCH*SLOT_W-1:0]     ch_slot,
   input  logic [SLOT_W-1:0]         q_slot,
   output logic                      q_hit,
   output logic [ch_bits(NCH)-1:0]   q_ch,
   output logic [SLOT_W-1:0]         last_slot
);
   localparam int CHW = ch_bits(NCH);

   always_comb begin
      q_hit     = 1'b0;
      q_ch      = '0;
      last_slot = '0;
      for (int c = NCH - 1; c >= 0; c--) begin
         if (ch_en[c] && (ch_slot[c*SLOT_W +: SLOT_W] == q_slot)) begin
            q_hit = 1'b1;
            q_ch  = CHW'(c);
         end
         if (ch_en[c] && (ch_slot[c*SLOT_W +: SLOT_W] > last_slot))
            last_slot = ch_slot[c*SLOT_W +: SLOT_W];
      end
   end
endmodule

// File: rtl/tdm_frmchk.sv
module tdm_frmchk #(
   parameter int NCH  = 4,
   parameter int WLW  = 5,
   parameter int OFFW = 8,
   parameter int CNTW = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick,
   input  logic            fs_edge,
   input  logic [NCH-1:0]  ch_en,
   input  logic [WLW-1:0]  wlen_m1,
   input  logic [OFFW-1:0] offset,
   output logic            frame_err
);
   logic [CNTW-1:0] cnt;
   logic [CNTW-1:0] need;
   logic            seen;

   always_comb begin
      need = CNTW'(offset);
      for (int c = 0; c < NCH; c++)
         if (ch_en[c]) need = need + CNTW'(wlen_m1) + CNTW'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt       <= '0;
         seen      <= 1'b0;
         frame_err <= 1'b0;
      end else if (tick) begin
         if (fs_edge) begin
            if (seen && (cnt < need)) frame_err <= 1'b1;
            cnt  <= CNTW'(1);
            seen <= 1'b1;
         end else if (cnt != '1) begin
            cnt <= cnt + CNTW'(1);
         end
      end
   end

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err |=> frame_err); // R7
   AST_ERR_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frame_err) |-> $past(fs_edge)); // R7
endmodule

// File: rtl/tdm_seq.sv
module tdm_seq
   import tdm_pkg::*;
#(
   parameter int NCH      = 4,
   parameter int WORD_MAX = 32,
   parameter int WLW      = 5,
   parameter int OFFW     = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    tick,
   input  logic                    fs_edge,
   input  logic [WLW-1:0]          wlen_m1,
   input  logic [OFFW-1:0]         offset,
   input  logic [NCH-1:0]          ch_en,
   input  logic [NCH*SLOT_W-1:0]   ch_slot,
   input  logic [NCH*WORD_MAX-1:0] samples,
   output logic                    sdout,
   output logic                    sdout_oe
);
   localparam int CHW = ch_bits(NCH);

   tx_st_e                  st;
   logic [SLOT_W-1:0]       slot_c;
   logic [WLW-1:0]          bit_c;
   logic [OFFW-1:0]         off_c;
   logic                    pend;
   logic [NCH*WORD_MAX-1:0] shadow;

   logic                    at_bound;
   logic                    start;
   logic                    emit;
   logic                    at_slot0;
   logic [SLOT_W-1:0]       e_slot;
   logic [WLW-1:0]          e_bit;
   logic                    hit;
   logic [CHW-1:0]          e_ch;
   logic [SLOT_W-1:0]       last_slot;
   logic [NCH*WORD_MAX-1:0] src;
   logic                    e_data;

   tdm_slotmap #(.NCH(NCH)) u_map (
      .ch_en     (ch_en),
      .ch_slot   (ch_slot),
      .q_slot    (e_slot),
      .q_hit     (hit),
      .q_ch      (e_ch),
      .last_slot (last_slot)
   );

   always_comb begin
      at_bound = (st != ST_SEND) || (bit_c == wlen_m1);
      start    = tick && (fs_edge || pend) && at_bound;
      at_slot0 = start || (st == ST_OFFS);
      e_slot   = at_slot0 ? '0 : slot_c;
      e_bit    = at_slot0 ? wlen_m1 : bit_c;
      if (start) emit = (offset == '0);
      else       emit = (st == ST_SEND) || ((st == ST_OFFS) && (off_c == '0));
      src      = start ? samples : shadow;
      e_data   = src[{e_ch, e_bit}];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         slot_c   <= '0;
         bit_c    <= '0;
         off_c    <= '0;
         pend     <= 1'b0;
         shadow   <= '0;
         sdout    <= 1'b0;
         sdout_oe <= 1'b0;
      end else if (tick) begin
         if (start) begin
            shadow <= samples;
            pend   <= 1'b0;
         end else if (fs_edge) begin
            pend <= 1'b1;
         end
         if (emit) begin
            sdout    <= hit & e_data;
            sdout_oe <= hit;
            if (e_bit == '0) begin
               if (e_slot >= last_slot) begin
                  st <= ST_IDLE;
               end else begin
                  st     <= ST_SEND;
                  slot_c <= e_slot + 1'b1;
                  bit_c  <= wlen_m1;
               end
            end else begin
               st     <= ST_SEND;
               slot_c <= e_slot;
               bit_c  <= e_bit - 1'b1;
            end
         end else begin
            sdout    <= 1'b0;
            sdout_oe <= 1'b0;
            if (start) begin
               st    <= ST_OFFS;
               off_c <= offset - 1'b1;
            end else if (st == ST_OFFS) begin
               off_c <= off_c - 1'b1;
            end
         end
      end
   end

   AST_QUIET_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      !sdout_oe |-> !sdout); // R5
   AST_HOLD_OFF_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> ($stable(sdout) && $stable(sdout_oe))); // R3
   AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && (st == ST_IDLE) && !start) |=> !sdout_oe); // R5
   AST_OFFS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && (st == ST_OFFS) && (off_c != '0) && !start) |=> !sdout_oe); // R1
   AST_PEND_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend) |-> $past(st == ST_SEND)); // R8
endmodule

// File: rtl/tdm_slot_tx.sv
module tdm_slot_tx
   import tdm_pkg::*;
#(
   parameter int NCH         = 4,
   parameter int WORD_MAX    = 32,
   parameter int OFFW        = 8,
   parameter int CNTW        = 16,
   parameter int SYNC_STAGES = 2,
   localparam int WLW        = $clog2(WORD_MAX)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    bclk,
   input  logic                    fsync,
   input  logic                    cfg_launch_fall,
   input  logic [WLW-1:0]          cfg_wlen_m1,
   input  logic [OFFW-1:0]         cfg_offset,
   input  logic [NCH-1:0]          cfg_ch_en,
   input  logic [NCH*SLOT_W-1:0]   cfg_ch_slot,
   input  logic [NCH*WORD_MAX-1:0] samples,
   output logic                    sdout,
   output logic                    sdout_oe,
   output logic                    frame_err
);
   generate
      if (NCH < 1 || NCH > SLOT_MAX) begin : g_bad_nch
         $error("tdm_slot_tx: NCH out of range");
      end
      if (WORD_MAX < 2 || WORD_MAX > 32 || (WORD_MAX & (WORD_MAX - 1)) != 0) begin : g_bad_word
         $error("tdm_slot_tx: WORD_MAX must be a power of two from 2 to 32");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("tdm_slot_tx: SYNC_STAGES out of range");
      end
      if (CNTW > 31 || (NCH * WORD_MAX + (1 << OFFW)) >= (1 << CNTW)) begin : g_bad_cnt
         $error("tdm_slot_tx: CNTW too narrow for the frame length check");
      end
   endgenerate

   logic tick;
   logic fs_edge;

   tdm_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk         (clk),
      .rst_n       (rst_n),
      .bclk        (bclk),
      .fsync       (fsync),
      .launch_fall (cfg_launch_fall),
      .tick        (tick),
      .fs_edge     (fs_edge)
   );

   tdm_seq #(
      .NCH      (NCH),
      .WORD_MAX (WORD_MAX),
      .WLW      (WLW),
      .OFFW     (OFFW)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .fs_edge  (fs_edge),
      .wlen_m1  (cfg_wlen_m1),
      .offset   (cfg_offset),
      .ch_en    (cfg_ch_en),
      .ch_slot  (cfg_ch_slot),
      .samples  (samples),
      .sdout    (sdout),
      .sdout_oe (sdout_oe)
   );

   tdm_frmchk #(
      .NCH  (NCH),
      .WLW  (WLW),
      .OFFW (OFFW),
      .CNTW (CNTW)
   ) u_chk (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .fs_edge   (fs_edge),
      .ch_en     (cfg_ch_en),
      .wlen_m1   (cfg_wlen_m1),
      .offset    (cfg_offset),
      .frame_err (frame_err)
   );
endmodule

// File: tb/sim_tdm_slot_tx.sv
module sim_tdm_slot_tx;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 8;

   typedef struct packed {
      logic        fall;
      logic [4:0]  wm1;
      logic [7:0]  off;
      logic [3:0]  en;
      logic [23:0] sl;
      logic [15:0] flen;
      logic        err;
      logic        chk;
   } vec_t;

   localparam vec_t VECS [NV] = '{
      '{1'b0, 5'd15, 8'd0, 4'b1111, {6'd3, 6'd2, 6'd1, 6'd0},  16'd64, 1'b0, 1'b1},
      '{1'b1, 5'd23, 8'd1, 4'b0011, {6'd0, 6'd0, 6'd1, 6'd0},  16'd64, 1'b0, 1'b1},
      '{1'b0, 5'd31, 8'd3, 4'b0101, {6'd0, 6'd0, 6'd0, 6'd2},  16'd100, 1'b0, 1'b1},
      '{1'b0, 5'd7,  8'd0, 4'b1000, {6'd5, 6'd0, 6'd0, 6'd0},  16'd48, 1'b0, 1'b1},
      '{1'b1, 5'd11, 8'd4, 4'b1111, {6'd0, 6'd1, 6'd2, 6'd3},  16'd52, 1'b0, 1'b1},
      '{1'b0, 5'd15, 8'd2, 4'b0111, {6'd0, 6'd2, 6'd1, 6'd0},  16'd49, 1'b1, 1'b0},
      '{1'b0, 5'd0,  8'd0, 4'b0011, {6'd0, 6'd0, 6'd1, 6'd0},  16'd4,  1'b0, 1'b1},
      '{1'b1, 5'd0,  8'd0, 4'b0001, {6'd0, 6'd0, 6'd0, 6'd63}, 16'd64, 1'b0, 1'b1}
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         bclk = 1'b0;
   logic         fsync = 1'b0;
   logic         cfg_fall = 1'b0;
   logic [4:0]   cfg_wm1 = '0;
   logic [7:0]   cfg_off = '0;
   logic [3:0]   cfg_en = '0;
   logic [23:0]  cfg_sl = '0;
   logic [127:0] smp = '0;
   logic         sdout;
   logic         sdout_oe;
   logic         frame_err;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   tdm_slot_tx u0 (
      .clk             (clk),
      .rst_n           (rst_n),
      .bclk            (bclk),
      .fsync           (fsync),
      .cfg_launch_fall (cfg_fall),
      .cfg_wlen_m1     (cfg_wm1),
      .cfg_offset      (cfg_off),
      .cfg_ch_en       (cfg_en),
      .cfg_ch_slot     (cfg_sl),
      .samples         (smp),
      .sdout           (sdout),
      .sdout_oe        (sdout_oe),
      .frame_err       (frame_err)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp,
                        input string what);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      fsync = 1'b0;
      bclk  = cfg_fall;
      wait_clk(4);
      rst_n = 1'b1;
      wait_clk(4);
   endtask

   task automatic bit_tick(input logic fs, output logic sd, output logic oe);
      bclk  = cfg_fall;
      fsync = fs;
      wait_clk(4);
      bclk = ~cfg_fall;
      wait_clk(7);
      sd = sdout;
      oe = sdout_oe;
      wait_clk(1);
   endtask

   function automatic logic [127:0] mk_smp(input int v);
      logic [127:0] r;
      for (int c = 0; c < 4; c++)
         r[c*32 +: 32] = 32'(32'h9E37_79B9 * (v * 4 + c + 1)) ^ 32'hC3A5_5A3C;
      return r;
   endfunction

   function automatic logic [1:0] expect_bit(input int k, input logic [4:0] wm1,
                                             input logic [7:0] off, input logic [3:0] en,
                                             input logic [23:0] sl, input logic [127:0] s);
      int w, d, slot, b, last;
      w = int'(wm1) + 1;
      d = k - int'(off);
      if (d < 0) return 2'b00;
      slot = d / w;
      b = w - 1 - (d % w);
      last = 0;
      for (int c = 0; c < 4; c++)
         if (en[c] && int'(sl[c*6 +: 6]) > last) last = int'(sl[c*6 +: 6]);
      if (slot > last) return 2'b00;
      for (int c = 0; c < 4; c++)
         if (en[c] && int'(sl[c*6 +: 6]) == slot) return {s[c*32 + b], 1'b1};
      return 2'b00;
   endfunction

   function automatic string vec_tag(input int v);
      case (v)
         0: return "R2";
         1: return "R3";
         2: return "R1";
         3: return "R5";
         4: return "R1";
         6: return "R4";
         7: return "R5";
         default: return "R7";
      endcase
   endfunction

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      logic sd, oe;
      logic [1:0] e;
      logic [127:0] smp_a, smp_b;

      // Table walk: one configuration per vector, three frames each
      for (int v = 0; v < NV; v++) begin
         cfg_fall = VECS[v].fall;
         cfg_wm1  = VECS[v].wm1;
         cfg_off  = VECS[v].off;
         cfg_en   = VECS[v].en;
         cfg_sl   = VECS[v].sl;
         smp      = mk_smp(v);
         do_reset();
         if (v == 0) begin
            check("R9", {31'd0, sdout}, 32'd0, "sdout after reset");
            check("R9", {31'd0, sdout_oe}, 32'd0, "oe after reset");
            check("R9", {31'd0, frame_err}, 32'd0, "frame_err after reset");
         end
         bit_tick(1'b0, sd, oe);
         check("R1", {30'd0, sd, oe}, 32'd0, "line idle before first frame");
         for (int f = 0; f < 3; f++) begin
            for (int k = 0; k < int'(VECS[v].flen); k++) begin
               bit_tick(k == 0, sd, oe);
               if (VECS[v].chk) begin
                  e = expect_bit(k, VECS[v].wm1, VECS[v].off, VECS[v].en, VECS[v].sl, smp);
                  check(vec_tag(v), {30'd0, sd, oe}, {30'd0, e}, $sformatf("vec %0d frame %0d bit %0d {sd,oe}", v, f, k));
               end
            end
         end
         bit_tick(1'b1, sd, oe);
         bit_tick(1'b0, sd, oe);
         check("R7", {31'd0, frame_err}, {31'd0, VECS[v].err}, $sformatf("vec %0d frame_err", v));
      end

      // Directed: capture at frame start, and a frame sync in the middle of a slot
      cfg_fall = 1'b0;
      cfg_wm1  = 5'd7;
      cfg_off  = 8'd0;
      cfg_en   = 4'b0111;
      cfg_sl   = {6'd0, 6'd2, 6'd1, 6'd0};
      smp_a    = mk_smp(20);
      smp_b    = mk_smp(21);
      smp      = smp_a;
      do_reset();
      check("R9", {31'd0, frame_err}, 32'd0, "frame_err cleared by reset (R7)");
      for (int k = 0; k < 16; k++) begin
         bit_tick((k == 0) || (k == 12), sd, oe);
         e = expect_bit(k, cfg_wm1, cfg_off, cfg_en, cfg_sl, smp_a);
         check((k < 12) ? "R6" : "R8", {30'd0, sd, oe}, {30'd0, e}, $sformatf("old frame bit %0d", k));
         if (k == 3) smp = smp_b;
      end
      for (int k = 0; k < 24; k++) begin
         bit_tick(1'b0, sd, oe);
         e = expect_bit(k, cfg_wm1, cfg_off, cfg_en, cfg_sl, smp_b);
         check("R8", {30'd0, sd, oe}, {30'd0, e}, $sformatf("resynced frame bit %0d", k));
      end
      bit_tick(1'b0, sd, oe);
      check("R8", {30'd0, sd, oe}, 32'd0, "line idle after resynced frame");
      check("R7", {31'd0, frame_err}, 32'd1, "short frame flagged");
      bit_tick(1'b0, sd, oe);
      check("R7", {31'd0, frame_err}, 32'd1, "flag stays set");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule